// File: doc/BRIEF.md
# Banked Interrupt Pending Register Bank

This block holds the pending state of every interrupt in an interrupt distributor that serves eight processor interfaces. Software reaches it through a byte-wide register port. Each access carries an offset, the number of the accessing CPU and a non-secure attribute. One window of offsets sets pending bits and a second window clears them. Inside a written byte, each 1 bit acts on one interrupt and each 0 bit leaves its interrupt alone.

Interrupts with an ID below 32 are private to each CPU. A write to one of them reaches only the bank of the CPU that made the access. Interrupts at 32 and above are shared, so a set or a clear of one of them acts on every CPU at once, whatever that interrupt's delivery targets are.

A group bit for each interrupt is loaded through a configuration port. When the security extension is on, non-secure accesses cannot see or change group-0 interrupts. A flat per-CPU pending vector feeds the downstream priority logic.

Top module: `irq_pend_bank`

## Requirements
- R1: After a synchronous reset every pending bit is 0, every group bit is 0 and `rd_data` is 0.
- R2: A set-pending write (offsets 0x200-0x27F) to an ID below 32 sets that ID only in the bank of the CPU given by `acc_cpu`. The other CPUs' banks keep their values.
- R3: A clear-pending write (offsets 0x280-0x2FF) to an ID below 32 clears it only in the accessing CPU's bank.
- R4: A set-pending write to an ID of 32 or above makes it pending on all 8 CPUs.
- R5: A clear-pending write to an ID of 32 or above clears it on all 8 CPUs.
- R6: Byte index k = offset minus window base. Bit i of `wr_data` acts on ID 8k+i. A 0 bit leaves its ID unchanged. The change is visible on `pend_vec` after the clock edge that samples `wr_en`.
- R7: When `sec_ext_en` is 1 and `acc_nonsec` is 1, a write skips every bit whose ID has group bit 0. Secure writes, and all writes while `sec_ext_en` is 0, are not filtered.
- R8: A read from either window returns the accessing CPU's view of IDs 8k..8k+7 on `rd_data`, bit i = ID 8k+i. The data appears one cycle after `rd_en` is sampled. Non-secure reads show group-0 IDs as 0 when `sec_ext_en` is 1. In a cycle that does not follow a read, `rd_data` is 0.
- R9: Accesses to IDs of 96 or more, and to offsets outside both windows, change no state, and reads of them return 0.
- R10: `cfg_we` loads `cfg_group` into the group bit of ID `cfg_id`. A group bit of 1 means group 1, which non-secure accesses may reach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| acc_addr | input | 12 | Byte offset of the access |
| acc_cpu | input | 3 | Number of the accessing CPU |
| acc_nonsec | input | 1 | Access is non-secure |
| wr_data | input | 8 | Write byte, one bit per interrupt |
| rd_data | output | 8 | Registered read byte |
| sec_ext_en | input | 1 | Security extension enabled |
| cfg_we | input | 1 | Group bit load strobe |
| cfg_id | input | 7 | Interrupt ID whose group bit is loaded |
| cfg_group | input | 1 | Group value to load (1 = group 1) |
| pend_vec | output | 768 | Pending bits, CPU c at [c*96 +: 96] |

## Verification
On every cycle, the assertions check four things. A write by one CPU never disturbs another CPU's private bank. Shared set and clear writes reach the addressed bits of the single shared store. A cycle with no active bit leaves all state alone. `rd_data` falls to 0 when no read was issued. Only the bench's scenarios can show the end-to-end results: the address-to-ID mapping, the fan-out of shared bits to all eight CPU views, the security filter depending on group bits loaded through the configuration port, and the per-CPU view returned by reads.

// File: rtl/pend_pkg.sv
package pend_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } pend_op_e;
endpackage

// File: rtl/pend_decode.sv
module pend_decode
  import pend_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SET_BASE  = 'h200,
  parameter int WIN_BYTES = 128,
  parameter int NUM_IRQ   = 96,
  localparam int WIN_W    = $clog2(WIN_BYTES),
  localparam int NUM_BYTES = NUM_IRQ / 8
) (
  input  logic [ADDR_W-1:0] addr,
  output pend_op_e          op,
  output logic [WIN_W-1:0]  byte_idx,
  output logic              in_range
);
  localparam int CLR_BASE = SET_BASE + WIN_BYTES;
  localparam logic [ADDR_W-WIN_W-1:0] SET_TAG = (ADDR_W-WIN_W)'(SET_BASE / WIN_BYTES);
  localparam logic [ADDR_W-WIN_W-1:0] CLR_TAG = (ADDR_W-WIN_W)'(CLR_BASE / WIN_BYTES);

  logic [ADDR_W-WIN_W-1:0] tag;

  always_comb begin
    tag      = addr[ADDR_W-1:WIN_W];
    byte_idx = addr[WIN_W-1:0];
    in_range = (32'(byte_idx) < NUM_BYTES);
    if (tag == SET_TAG)      op = OP_SET;
    else if (tag == CLR_TAG) op = OP_CLR;
    else                     op = OP_NONE;
  end
endmodule

// File: rtl/pend_group.sv
module pend_group #(
  parameter int NUM_IRQ   = 96,
  parameter int WIN_BYTES = 128,
  localparam int IRQ_W    = $clog2(NUM_IRQ),
  localparam int WIN_W    = $clog2(WIN_BYTES),
  localparam int NUM_BYTES = NUM_IRQ / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IRQ_W-1:0] cfg_id,
  input  logic             cfg_group,
  input  logic [WIN_W-1:0] byte_idx,
  input  logic             filt_on,
  output logic [7:0]       allow
);
  logic [NUM_IRQ-1:0] grp_q;
  logic [7:0]         grp_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0;
    end else if (cfg_we && (32'(cfg_id) < NUM_IRQ)) begin
      grp_q[cfg_id] <= cfg_group;
    end
  end

  always_comb begin
    grp_byte = 8'h00;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (32'(byte_idx) == b) grp_byte = grp_q[b*8 +: 8];
    end
    allow = grp_byte | {8{~filt_on}};
  end
endmodule

// File: rtl/pend_store.sv
module pend_store
  import pend_pkg::*;
#(
  parameter int NUM_CPU   = 8,
  parameter int NUM_IRQ   = 96,
  parameter int NUM_PRIV  = 32,
  parameter int WIN_BYTES = 128,
  localparam int CPU_W    = $clog2(NUM_CPU),
  localparam int WIN_W    = $clog2(WIN_BYTES),
  localparam int NUM_SH   = NUM_IRQ - NUM_PRIV
) (
  input  logic                       clk,
  input  logic                       rst,
  input  pend_op_e                   wr_op,
  input  logic [CPU_W-1:0]           wr_cpu,
  input  logic [WIN_W-1:0]           byte_idx,
  input  logic [7:0]                 wr_mask,
  input  logic [CPU_W-1:0]           rd_cpu,
  output logic [7:0]                 rd_byte,
  output logic [NUM_CPU*NUM_IRQ-1:0] pend_vec
);
  logic [NUM_CPU-1:0][NUM_PRIV-1:0] priv_q;
  logic [NUM_SH-1:0]                shared_q;
  logic [NUM_PRIV-1:0]              pv_hit;
  logic [NUM_SH-1:0]                sh_hit;
  logic [NUM_IRQ-1:0]               view;

  generate
    for (genvar p = 0; p < NUM_PRIV; p++) begin : g_pv_hit
      assign pv_hit[p] = (wr_op != OP_NONE) && (32'(byte_idx) == p / 8) && wr_mask[p % 8];
    end
    for (genvar s = 0; s < NUM_SH; s++) begin : g_sh_hit
      assign sh_hit[s] = (wr_op != OP_NONE) && (32'(byte_idx) == (NUM_PRIV + s) / 8)
                         && wr_mask[(NUM_PRIV + s) % 8];
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          priv_q[c] <= '0;
        end else if (wr_cpu == CPU_W'(c)) begin
          if (wr_op == OP_SET)      priv_q[c] <= priv_q[c] | pv_hit;
          else if (wr_op == OP_CLR) priv_q[c] <= priv_q[c] & ~pv_hit;
        end
      end
      assign pend_vec[c*NUM_IRQ +: NUM_IRQ] = {shared_q, priv_q[c]};

      AST_OTHER_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_cpu != CPU_W'(c)) |=> $stable(priv_q[c])); // R2
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_q <= '0;
    end else if (wr_op == OP_SET) begin
      shared_q <= shared_q | sh_hit;
    end else if (wr_op == OP_CLR) begin
      shared_q <= shared_q & ~sh_hit;
    end
  end

  always_comb begin
    view    = {shared_q, priv_q[rd_cpu]};
    rd_byte = 8'h00;
    for (int b = 0; b < NUM_IRQ / 8; b++) begin
      if (32'(byte_idx) == b) rd_byte = view[b*8 +: 8];
    end
  end

  AST_SHARED_SET_ALL: assert property (@(posedge clk) disable iff (rst)
    (wr_op == OP_SET) |=> ((shared_q & $past(sh_hit)) == $past(sh_hit))); // R4
  AST_SHARED_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
    (wr_op == OP_CLR) |=> ((shared_q & $past(sh_hit)) == '0)); // R5
  AST_IDLE_SHARED_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sh_hit == '0) |=> $stable(shared_q)); // R6
  AST_IDLE_PRIV_STABLE: assert property (@(posedge clk) disable iff (rst)
    (pv_hit == '0) |=> $stable(priv_q)); // R6
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import pend_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CPU   = 8,
  parameter int NUM_IRQ   = 96,
  parameter int NUM_PRIV  = 32,
  parameter int SET_BASE  = 'h200,
  parameter int WIN_BYTES = 128,
  localparam int CPU_W    = $clog2(NUM_CPU),
  localparam int IRQ_W    = $clog2(NUM_IRQ),
  localparam int WIN_W    = $clog2(WIN_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [CPU_W-1:0]           acc_cpu,
  input  logic                       acc_nonsec,
  input  logic [7:0]                 wr_data,
  output logic [7:0]                 rd_data,
  input  logic                       sec_ext_en,
  input  logic                       cfg_we,
  input  logic [IRQ_W-1:0]           cfg_id,
  input  logic                       cfg_group,
  output logic [NUM_CPU*NUM_IRQ-1:0] pend_vec
);
  pend_op_e         dec_op;
  pend_op_e         wr_op;
  logic [WIN_W-1:0] byte_idx;
  logic             in_range;
  logic [7:0]       allow;
  logic [7:0]       rd_byte;
  logic             filt_on;

  assign filt_on = sec_ext_en && acc_nonsec;

  pend_decode #(
    .ADDR_W(ADDR_W), .SET_BASE(SET_BASE), .WIN_BYTES(WIN_BYTES), .NUM_IRQ(NUM_IRQ)
  ) u_decode (
    .addr(acc_addr), .op(dec_op), .byte_idx(byte_idx), .in_range(in_range)
  );

  pend_group #(
    .NUM_IRQ(NUM_IRQ), .WIN_BYTES(WIN_BYTES)
  ) u_group (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_group(cfg_group),
    .byte_idx(byte_idx), .filt_on(filt_on), .allow(allow)
  );

  assign wr_op = (wr_en && in_range) ? dec_op : OP_NONE;

  pend_store #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .WIN_BYTES(WIN_BYTES)
  ) u_store (
    .clk(clk), .rst(rst), .wr_op(wr_op), .wr_cpu(acc_cpu), .byte_idx(byte_idx),
    .wr_mask(wr_data & allow), .rd_cpu(acc_cpu), .rd_byte(rd_byte), .pend_vec(pend_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (rd_en && in_range && (dec_op != OP_NONE)) begin
      rd_data <= rd_byte & allow;
    end else begin
      rd_data <= 8'h00;
    end
  end

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == 8'h00)); // R8
endmodule

// File: tb/irq_pend_bank_tb.sv
module irq_pend_bank_tb_top;
  localparam int NC = 8;
  localparam int NI = 96;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   acc_addr = '0;
  logic [2:0]    acc_cpu = '0;
  logic          acc_nonsec = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          sec_ext_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [6:0]    cfg_id = '0;
  logic          cfg_group = 1'b0;
  logic [NC*NI-1:0] pend_vec;
  logic [NC*NI-1:0] snap;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_pend_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .acc_addr(acc_addr),
    .acc_cpu(acc_cpu), .acc_nonsec(acc_nonsec), .wr_data(wr_data), .rd_data(rd_data),
    .sec_ext_en(sec_ext_en), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_group(cfg_group),
    .pend_vec(pend_vec)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pb(input int c, input int id);
    return int'(pend_vec[c*NI + id]);
  endfunction

  task automatic reg_write(input int cpu, input int addr, input int data, input bit ns);
    @(negedge clk);
    wr_en = 1'b1; acc_cpu = 3'(cpu); acc_addr = 12'(addr); wr_data = 8'(data); acc_nonsec = ns;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_read(input int cpu, input int addr, input bit ns, output int val);
    @(negedge clk);
    rd_en = 1'b1; acc_cpu = 3'(cpu); acc_addr = 12'(addr); acc_nonsec = ns;
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data);
  endtask

  task automatic set_group(input int id, input bit g);
    @(negedge clk);
    cfg_we = 1'b1; cfg_id = 7'(id); cfg_group = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "pend_vec after reset", int'(pend_vec != '0), 0);
    check("R1", "rd_data after reset", int'(rd_data), 0);
  endtask

  task automatic t_private();
    reg_write(2, 'h200, 'h05, 0);
    check("R2", "cpu2 id0", pb(2, 0), 1);
    check("R2", "cpu2 id2", pb(2, 2), 1);
    check("R6", "cpu2 id1 untouched", pb(2, 1), 0);
    check("R2", "cpu3 id0", pb(3, 0), 0);
    reg_write(5, 'h200, 'h01, 0);
    reg_write(2, 'h280, 'h01, 0);
    check("R3", "cpu2 id0 cleared", pb(2, 0), 0);
    check("R3", "cpu2 id2 kept", pb(2, 2), 1);
    check("R3", "cpu5 id0 kept", pb(5, 0), 1);
  endtask

  task automatic t_shared();
    reg_write(1, 'h205, 'h81, 0);
    for (int c = 0; c < NC; c++) begin
      check("R4", "id40 on every cpu", pb(c, 40), 1);
      check("R4", "id47 on every cpu", pb(c, 47), 1);
    end
    reg_write(7, 'h285, 'h80, 0);
    for (int c = 0; c < NC; c++) begin
      check("R5", "id47 cleared every cpu", pb(c, 47), 0);
      check("R6", "id40 kept", pb(c, 40), 1);
    end
  endtask

  task automatic t_security();
    sec_ext_en = 1'b1;
    reg_write(0, 'h207, 'h10, 1);
    check("R10", "id60 group0 after reset blocks nonsec", pb(0, 60), 0);
    set_group(50, 1'b1);
    set_group(51, 1'b0);
    reg_write(4, 'h206, 'h0C, 1);
    check("R7", "nonsec set group1 id50", pb(4, 50), 1);
    check("R7", "nonsec set group0 id51 skipped", pb(4, 51), 0);
    reg_write(4, 'h206, 'h08, 0);
    check("R7", "secure set id51", pb(6, 51), 1);
    reg_write(3, 'h286, 'h0C, 1);
    check("R7", "nonsec clear id50", pb(3, 50), 0);
    check("R7", "nonsec clear id51 skipped", pb(3, 51), 1);
    sec_ext_en = 1'b0;
    reg_write(3, 'h286, 'h08, 1);
    check("R7", "filter off clears id51", pb(3, 51), 0);
  endtask

  task automatic t_read();
    int v;
    reg_write(3, 'h201, 'h06, 0);
    reg_read(3, 'h201, 0, v);
    check("R8", "cpu3 view ids 8-15", v, 'h06);
    reg_read(4, 'h201, 0, v);
    check("R8", "cpu4 view ids 8-15", v, 'h00);
    reg_read(3, 'h281, 0, v);
    check("R8", "clear window read", v, 'h06);
    reg_read(0, 'h205, 0, v);
    check("R8", "shared id40 read", v, 'h01);
    sec_ext_en = 1'b1;
    reg_write(0, 'h206, 'h0C, 0);
    reg_read(2, 'h206, 1, v);
    check("R8", "nonsec read hides group0", v, 'h04);
    reg_read(2, 'h206, 0, v);
    check("R8", "secure read", v, 'h0C);
    @(negedge clk);
    check("R8", "rd_data idle", int'(rd_data), 0);
    sec_ext_en = 1'b0;
  endtask

  task automatic t_range();
    int v;
    snap = pend_vec;
    reg_write(0, 'h20C, 'hFF, 0);
    reg_write(0, 'h300, 'hFF, 0);
    reg_write(0, 'h1FF, 'hFF, 0);
    reg_write(0, 'h28C, 'hFF, 0);
    check("R9", "out of range writes ignored", int'(pend_vec != snap), 0);
    reg_read(3, 'h20C, 0, v);
    check("R9", "read beyond ids", v, 0);
    reg_read(3, 'h101, 0, v);
    check("R9", "read outside windows", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_private();
    t_shared();
    t_security();
    t_read();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule